// File: doc/BRIEF.md
# Compressed Stack-Operation and Double-Precision Slot Decoder

This block classifies a 16-bit compressed instruction word into one operation kind. Two instruction groups share the same encoding space: the compressed double-precision floating-point loads and stores, and the stack push/pop/register-move group. A static mode input chooses which of the two owns that space. When the mode input is high, the shared slots decode as floating-point loads and stores. When it is low, one slot decodes as the push/pop/move group, and the other former floating-point slots are reported as illegal.

The result is a one-hot operation vector. The block also returns the raw register-list and stack-adjust fields, and two saved-register selectors already converted to architectural integer register numbers. It is purely combinational and is meant to sit beside the main compressed decoder. Any encoding outside the shared slots is reported as "other" and left to the rest of the decoder.

Top module: `cslot_decoder`

## Requirements
- R1: Exactly one bit of `op_onehot` is set for every input. The bit positions are: 0 fld, 1 fsd, 2 fldsp, 3 fsdsp, 4 push, 5 pop, 6 popret, 7 popretz, 8 mvsa01, 9 mva01s, 10 illegal, 11 other.
- R2: With `dp_enable`=1, the following slots decode as floating-point operations. Quadrant 0 (bits 1:0 = 00) with bits 15:13 = 001 gives fld, and with bits 15:13 = 101 gives fsd. Quadrant 2 (bits 1:0 = 10) with bits 15:13 = 001 gives fldsp, and with bits 15:13 = 101 gives fsdsp. This holds whatever the other bits are.
- R3: With `dp_enable`=0, three slots are illegal: quadrant 0 with bits 15:13 = 001, quadrant 0 with bits 15:13 = 101, and quadrant 2 with bits 15:13 = 001. No floating-point kind is ever reported in this mode.
- R4: With `dp_enable`=0, quadrant 2 with bits 15:13 = 101 is the stack group. Inside it, bits 12:10 = 011 together with bits 6:5 = 01 gives mvsa01, and with bits 6:5 = 11 gives mva01s. Bits 6:5 = 00 or 10 are illegal.
- R5: In the stack group, bits 12:10 = 110 gives push when bits 9:8 = 00 and pop when bits 9:8 = 10. Bits 12:10 = 111 gives popretz when bits 9:8 = 00 and popret when bits 9:8 = 10. Bits 9:8 = 01 or 11 are illegal.
- R6: A push, pop, popret or popretz whose register list (bits 7:4) is below 4 is reported as illegal.
- R7: Stack-group words with bits 12:10 equal to 000, 001, 010, 100 or 101 are illegal.
- R8: `rlist` always equals bits 7:4 and `spimm` always equals bits 3:2, for every operation kind.
- R9: `sreg1` is derived from bits 9:7 and `sreg2` from bits 4:2. Selector value 0 maps to register 8, value 1 to register 9, and values 2 to 7 map to registers 18 to 23.
- R10: All other words report "other" in both modes. This covers quadrant 1, quadrant 3 (bits 1:0 = 11), and quadrants 0 and 2 with any bits 15:13 value other than 001 or 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dp_enable | input | 1 | Static mode: 1 = double-precision slots, 0 = stack group |
| instr | input | 16 | Compressed instruction word |
| op_onehot | output | 12 | One-hot operation kind (bit map in R1) |
| rlist | output | 4 | Register-list field, bits 7:4 |
| spimm | output | 2 | Extra stack-adjust field, bits 3:2 |
| sreg1 | output | 5 | First saved register number, from bits 9:7 |
| sreg2 | output | 5 | Second saved register number, from bits 4:2 |

## Verification
The bound checker samples every cycle and checks that the operation vector is one-hot. It also checks that the mode input never lets a floating-point kind and a stack-group kind appear in the wrong mode, that no push or pop kind appears with a register list below 4, and that both selector outputs always land in the saved-register set. Only the directed scenarios can show that each particular bit pattern lands on the correct kind. Examples are the exact split between mvsa01 and mva01s, the two return variants, and the register number picked for a given selector value.

// File: rtl/cslot_pkg.sv
// Shared constants for the compressed shared-slot decoder.
// Assumes a 16-bit compressed word with quadrant in bits 1:0 and funct3 in 15:13.
package cslot_pkg;
    localparam int INSTR_W   = 16;
    localparam int REG_W     = 5;
    localparam int SEL_W     = 3;
    localparam int RLIST_W   = 4;
    localparam int SPIMM_W   = 2;
    localparam int MIN_RLIST = 4;

    // One-hot operation positions.
    localparam int OP_FLD     = 0;
    localparam int OP_FSD     = 1;
    localparam int OP_FLDSP   = 2;
    localparam int OP_FSDSP   = 3;
    localparam int OP_PUSH    = 4;
    localparam int OP_POP     = 5;
    localparam int OP_POPRET  = 6;
    localparam int OP_POPRETZ = 7;
    localparam int OP_MVSA    = 8;
    localparam int OP_MVAS    = 9;
    localparam int OP_ILLEGAL = 10;
    localparam int OP_OTHER   = 11;
    localparam int OP_COUNT   = 12;

    typedef logic [OP_COUNT-1:0] op_vec_t;

    localparam logic [1:0] QUAD0 = 2'b00;
    localparam logic [1:0] QUAD2 = 2'b10;
    localparam logic [2:0] F3_LD = 3'b001;
    localparam logic [2:0] F3_SD = 3'b101;
endpackage

// File: rtl/cslot_classify.sv
// Slot classifier: decides whether a word falls in one of the four shared slots
// and, given the mode bit, whether it is a floating-point op, blocked (illegal),
// the stack group, or outside the shared space. Assumes a static mode bit.
module cslot_classify
    import cslot_pkg::*;
(
    input  logic       dp_en,
    input  logic [1:0] quad,
    input  logic [2:0] funct3,
    output logic [3:0] fp_hit,
    output logic       blocked,
    output logic       stack_grp,
    output logic       outside
);
    logic [3:0] slot;

    // Locate which of the four shared slots the word occupies.
    always_comb begin
        slot[0] = (quad == QUAD0) && (funct3 == F3_LD);
        slot[1] = (quad == QUAD0) && (funct3 == F3_SD);
        slot[2] = (quad == QUAD2) && (funct3 == F3_LD);
        slot[3] = (quad == QUAD2) && (funct3 == F3_SD);
    end

    // Apply the mode bit to the slot hit.
    always_comb begin
        fp_hit    = dp_en ? slot : 4'b0000;
        stack_grp = !dp_en && slot[3];
        blocked   = !dp_en && (slot[0] || slot[1] || slot[2]);
        outside   = (slot == 4'b0000);
    end
endmodule

// File: rtl/cslot_stackops.sv
// Stack-group sub-decoder: splits push/pop/return/move variants out of the
// shared slot word. Assumes the caller only uses it when the stack group is active.
module cslot_stackops
    import cslot_pkg::*;
#(
    parameter int RL_W   = RLIST_W,
    parameter int RL_MIN = MIN_RLIST
)(
    input  logic [2:0]      sel_hi,
    input  logic [1:0]      sel_mid,
    input  logic [1:0]      sel_lo,
    input  logic [RL_W-1:0] rl,
    output op_vec_t         ops
);
    localparam logic [RL_W-1:0] RL_FLOOR = RL_W'(RL_MIN);

    logic rl_ok;

    // Register list must cover at least the return-address entry.
    always_comb rl_ok = (rl >= RL_FLOOR);

    // Pick exactly one kind; anything unlisted becomes illegal.
    always_comb begin
        ops = '0;
        unique case (sel_hi)
            3'b011: begin
                if (sel_lo == 2'b01)      ops[OP_MVSA] = 1'b1;
                else if (sel_lo == 2'b11) ops[OP_MVAS] = 1'b1;
                else                      ops[OP_ILLEGAL] = 1'b1;
            end
            3'b110: begin
                if (!rl_ok)                ops[OP_ILLEGAL] = 1'b1;
                else if (sel_mid == 2'b00) ops[OP_PUSH] = 1'b1;
                else if (sel_mid == 2'b10) ops[OP_POP] = 1'b1;
                else                       ops[OP_ILLEGAL] = 1'b1;
            end
            3'b111: begin
                if (!rl_ok)                ops[OP_ILLEGAL] = 1'b1;
                else if (sel_mid == 2'b00) ops[OP_POPRETZ] = 1'b1;
                else if (sel_mid == 2'b10) ops[OP_POPRET] = 1'b1;
                else                       ops[OP_ILLEGAL] = 1'b1;
            end
            default: ops[OP_ILLEGAL] = 1'b1;
        endcase
    end
endmodule

// File: rtl/cslot_sreg_map.sv
// Saved-register mapper: turns a 3-bit selector into an architectural register
// number from the non-contiguous saved set (8, 9, then 18..23).
module cslot_sreg_map
    import cslot_pkg::*;
#(
    parameter int SW       = SEL_W,
    parameter int RW       = REG_W,
    parameter int LOW_BASE = 8,
    parameter int HI_BASE  = 16
)(
    input  logic [SW-1:0] sel,
    output logic [RW-1:0] reg_num
);
    // First two selectors sit low, the rest in the upper bank.
    always_comb begin
        if (sel < SW'(2)) reg_num = RW'(LOW_BASE) + RW'(sel);
        else              reg_num = RW'(HI_BASE) + RW'(sel);
    end
endmodule

// File: rtl/cslot_decoder.sv
// Top: shared-slot compressed decoder. Combines the slot classifier, the
// stack-group sub-decoder and two saved-register mappers into a one-hot kind
// plus field outputs. Purely combinational; dp_enable is assumed static.
module cslot_decoder
    import cslot_pkg::*;
(
    input  logic                 dp_enable,
    input  logic [INSTR_W-1:0]   instr,
    output logic [OP_COUNT-1:0]  op_onehot,
    output logic [RLIST_W-1:0]   rlist,
    output logic [SPIMM_W-1:0]   spimm,
    output logic [REG_W-1:0]     sreg1,
    output logic [REG_W-1:0]     sreg2
);
    logic [3:0] fp_hit;
    logic       blocked, stack_grp, outside;
    op_vec_t    stack_ops;
    logic [SEL_W-1:0] sel_a [2];
    logic [REG_W-1:0] reg_a [2];

    cslot_classify u_class (
        .dp_en     (dp_enable),
        .quad      (instr[1:0]),
        .funct3    (instr[15:13]),
        .fp_hit    (fp_hit),
        .blocked   (blocked),
        .stack_grp (stack_grp),
        .outside   (outside)
    );

    cslot_stackops u_stack (
        .sel_hi  (instr[12:10]),
        .sel_mid (instr[9:8]),
        .sel_lo  (instr[6:5]),
        .rl      (instr[7:4]),
        .ops     (stack_ops)
    );

    // Route the two selector fields to the mappers.
    always_comb begin
        sel_a[0] = instr[9:7];
        sel_a[1] = instr[4:2];
    end

    for (genvar g = 0; g < 2; g++) begin : g_map
        cslot_sreg_map u_map (
            .sel     (sel_a[g]),
            .reg_num (reg_a[g])
        );
    end

    // Merge the classifier and sub-decoder into one kind.
    always_comb begin
        op_onehot = '0;
        if (outside)        op_onehot[OP_OTHER] = 1'b1;
        else if (blocked)   op_onehot[OP_ILLEGAL] = 1'b1;
        else if (stack_grp) op_onehot = stack_ops;
        else                op_onehot[OP_FSDSP:OP_FLD] = fp_hit;
    end

    // Pass raw fields and mapped registers out unconditionally.
    always_comb begin
        rlist = instr[7:4];
        spimm = instr[3:2];
        sreg1 = reg_a[0];
        sreg2 = reg_a[1];
    end
endmodule

// File: rtl/cslot_decoder_chk.sv
// Checker for cslot_decoder: port-level invariants evaluated on settled values.
module cslot_decoder_chk
    import cslot_pkg::*;
(
    input logic                dp_enable,
    input logic [INSTR_W-1:0]  instr,
    input logic [OP_COUNT-1:0] op_onehot,
    input logic [RLIST_W-1:0]  rlist,
    input logic [REG_W-1:0]    sreg1,
    input logic [REG_W-1:0]    sreg2
);
    function automatic logic saved_reg(input logic [REG_W-1:0] r);
        return (r == 5'd8) || (r == 5'd9) || ((r >= 5'd18) && (r <= 5'd23));
    endfunction

    // Invariants across inputs and outputs.
    always_comb begin
        p_onehot_r1: assert ($countones(op_onehot) == 1)
            else $error("op_onehot not one-hot");
        p_fp_mode_r2: assert (dp_enable || (op_onehot[OP_FSDSP:OP_FLD] == 4'b0))
            else $error("fp kind in stack mode");
        p_stack_mode_r4: assert (!dp_enable || (op_onehot[OP_MVAS:OP_PUSH] == 6'b0))
            else $error("stack kind in fp mode");
        p_rlist_floor_r6: assert ((rlist >= 4'd4) || (op_onehot[OP_POPRETZ:OP_PUSH] == 4'b0))
            else $error("push/pop with short list");
        p_quad3_other_r10: assert ((instr[1:0] != 2'b11) || op_onehot[OP_OTHER])
            else $error("quadrant 3 not other");
        p_sreg_set_r9: assert (saved_reg(sreg1) && saved_reg(sreg2))
            else $error("selector outside saved set");
    end
endmodule

bind cslot_decoder cslot_decoder_chk chk_i (
    .dp_enable (dp_enable),
    .instr     (instr),
    .op_onehot (op_onehot),
    .rlist     (rlist),
    .sreg1     (sreg1),
    .sreg2     (sreg2)
);

// File: tb/cslot_decoder_tb_top.sv
// Directed bench for cslot_decoder: one task per scenario.
module cslot_decoder_tb_top;
    logic        clk = 1'b0;
    logic        dp_enable;
    logic [15:0] instr;
    logic [11:0] op_onehot;
    logic [3:0]  rlist;
    logic [1:0]  spimm;
    logic [4:0]  sreg1, sreg2;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cslot_decoder dut_i (
        .dp_enable (dp_enable),
        .instr     (instr),
        .op_onehot (op_onehot),
        .rlist     (rlist),
        .spimm     (spimm),
        .sreg1     (sreg1),
        .sreg2     (sreg2)
    );

    // Word = funct3 | bits12:10 | bits9:7 | bits6:2 | quadrant
    function automatic logic [15:0] enc(input logic [2:0] f3, input logic [2:0] hi,
                                        input logic [2:0] mid, input logic [4:0] lo,
                                        input logic [1:0] q);
        return {f3, hi, mid, lo, q};
    endfunction

    // Push/pop form: bits9:8 sub, bits7:4 list, bits3:2 adj
    function automatic logic [15:0] stk(input logic [2:0] hi, input logic [1:0] sub,
                                        input logic [3:0] rl, input logic [1:0] adj);
        return {3'b101, hi, sub, rl, adj, 2'b10};
    endfunction

    task automatic apply(input logic en, input logic [15:0] w);
        @(negedge clk);
        dp_enable = en;
        instr     = w;
        #1;
    endtask

    task automatic chk_op(input string tag, input int exp_bit);
        logic [11:0] exp_v;
        exp_v = 12'b1 << exp_bit;
        checks++;
        if (op_onehot !== exp_v) begin
            fails++;
            $display("FAIL %s instr=%h op actual=%b expected=%b", tag, instr, op_onehot, exp_v);
        end
    endtask

    task automatic chk_val(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic t_initial();
        apply(1'b1, 16'h0000);
        chk_op("R10 initial zero word", 11);
        chk_op("R1 initial one-hot", 11);
    endtask

    task automatic t_fp_mode();
        apply(1'b1, enc(3'b001, 3'b010, 3'b111, 5'b01010, 2'b00)); chk_op("R2 fld", 0);
        apply(1'b1, enc(3'b101, 3'b000, 3'b001, 5'b11111, 2'b00)); chk_op("R2 fsd", 1);
        apply(1'b1, enc(3'b001, 3'b111, 3'b000, 5'b00000, 2'b10)); chk_op("R2 fldsp", 2);
        apply(1'b1, stk(3'b110, 2'b00, 4'd7, 2'd2));               chk_op("R2 fsdsp over push bits", 3);
    endtask

    task automatic t_blocked();
        apply(1'b0, enc(3'b001, 3'b010, 3'b111, 5'b01010, 2'b00)); chk_op("R3 q0 001 illegal", 10);
        apply(1'b0, enc(3'b101, 3'b000, 3'b001, 5'b11111, 2'b00)); chk_op("R3 q0 101 illegal", 10);
        apply(1'b0, enc(3'b001, 3'b111, 3'b000, 5'b00000, 2'b10)); chk_op("R3 q2 001 illegal", 10);
    endtask

    task automatic t_moves();
        apply(1'b0, enc(3'b101, 3'b011, 3'd3, {2'b01, 3'd5}, 2'b10));
        chk_op("R4 mvsa01", 8);
        chk_val("R9 sreg1 sel3", sreg1, 19);
        chk_val("R9 sreg2 sel5", sreg2, 21);
        apply(1'b0, enc(3'b101, 3'b011, 3'd0, {2'b11, 3'd1}, 2'b10));
        chk_op("R4 mva01s", 9);
        chk_val("R9 sreg1 sel0", sreg1, 8);
        chk_val("R9 sreg2 sel1", sreg2, 9);
        apply(1'b0, enc(3'b101, 3'b011, 3'd2, {2'b00, 3'd7}, 2'b10));
        chk_op("R4 move bits6:5=00 illegal", 10);
        chk_val("R9 sreg1 sel2", sreg1, 18);
        chk_val("R9 sreg2 sel7", sreg2, 23);
        apply(1'b0, enc(3'b101, 3'b011, 3'd2, {2'b10, 3'd7}, 2'b10));
        chk_op("R4 move bits6:5=10 illegal", 10);
    endtask

    task automatic t_pushpop();
        apply(1'b0, stk(3'b110, 2'b00, 4'd7, 2'd2));
        chk_op("R5 push", 4);
        chk_val("R8 rlist push", rlist, 7);
        chk_val("R8 spimm push", spimm, 2);
        apply(1'b0, stk(3'b110, 2'b10, 4'd15, 2'd3));
        chk_op("R5 pop", 5);
        chk_val("R8 rlist pop", rlist, 15);
        chk_val("R8 spimm pop", spimm, 3);
        apply(1'b0, stk(3'b111, 2'b00, 4'd4, 2'd0)); chk_op("R5 popretz at list floor", 7);
        apply(1'b0, stk(3'b111, 2'b10, 4'd12, 2'd1)); chk_op("R5 popret", 6);
        apply(1'b0, stk(3'b110, 2'b01, 4'd8, 2'd0)); chk_op("R5 bits9:8=01 illegal", 10);
        apply(1'b0, stk(3'b111, 2'b11, 4'd8, 2'd0)); chk_op("R5 bits9:8=11 illegal", 10);
    endtask

    task automatic t_short_list();
        apply(1'b0, stk(3'b110, 2'b00, 4'd3, 2'd1));
        chk_op("R6 push list 3 illegal", 10);
        chk_val("R8 rlist on illegal", rlist, 3);
        apply(1'b0, stk(3'b110, 2'b10, 4'd0, 2'd0)); chk_op("R6 pop list 0 illegal", 10);
        apply(1'b0, stk(3'b111, 2'b10, 4'd2, 2'd0)); chk_op("R6 popret list 2 illegal", 10);
    endtask

    task automatic t_unlisted();
        apply(1'b0, stk(3'b000, 2'b00, 4'd8, 2'd0)); chk_op("R7 bits12:10=000 illegal", 10);
        apply(1'b0, stk(3'b100, 2'b00, 4'd8, 2'd0)); chk_op("R7 bits12:10=100 illegal", 10);
        apply(1'b0, stk(3'b101, 2'b10, 4'd8, 2'd0)); chk_op("R7 bits12:10=101 illegal", 10);
    endtask

    task automatic t_other();
        apply(1'b0, enc(3'b001, 3'b000, 3'b000, 5'b00001, 2'b01)); chk_op("R10 quadrant 1", 11);
        apply(1'b1, enc(3'b101, 3'b110, 3'b000, 5'b11100, 2'b11)); chk_op("R10 quadrant 3", 11);
        apply(1'b0, enc(3'b010, 3'b000, 3'b000, 5'b00000, 2'b10)); chk_op("R10 q2 f3 010", 11);
        apply(1'b1, enc(3'b110, 3'b000, 3'b000, 5'b00000, 2'b00)); chk_op("R10 q0 f3 110", 11);
    endtask

    initial begin
        dp_enable = 1'b1;
        instr     = 16'h0000;
        t_initial();
        t_fp_mode();
        t_blocked();
        t_moves();
        t_pushpop();
        t_short_list();
        t_unlisted();
        t_other();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule